// File: doc/BRIEF.md
# Transmit Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate calibration for one port without software involvement. After a start pulse it switches on the port's ring oscillator and waits for it to settle. It then drives a register-style master port toward an on-chip frequency meter: it enables the meter's free-running clock, programs the meter's cycle count and channel, and arms the meter. It reads the status register at a fixed interval until the meter reports a valid result, or until the poll budget runs out. It reads the result either way.

After the result is read, the sequencer disarms the meter and stops its free-running clock. It then turns the measured count into a 3-bit slew-rate code and drives that code to the transmitter. Finally it switches the oscillator off and pulses done. The code is the nearest integer to (1024·26·28 / count) / 1000, where the inner division truncates. A multi-cycle restoring divider does the division, and a ladder of threshold comparators does the rounding. A zero count yields the fallback code. Settling time, poll interval and poll budget are parameters, given in clock cycles.

Top module: `srcal_seq`

## Requirements
- R1: Out of reset, osc_en_o is 0, code_o is 4, done_o is 0 and reg_req_o is 0.
- R2: After start_i in idle, osc_en_o rises first. At least SETTLE_CYC cycles later the first bus transaction writes 1 to address 1, the free-run clock enable. A transaction completes in the cycle where reg_req_o and reg_ack_i are both high, and the request holds address, direction and data stable until then.
- R3: Address 0 is then written twice. The first write carries the cycle count 1024 in bits 23:0, the port index latched at start in bits 25:24, and bit 28 clear. The second write carries the same word with bit 28, the meter enable, set.
- R4: The sequencer then reads address 2, the status register, at least POLL_CYC cycles apart. A read returning bit 0 set ends polling, and the next transaction reads address 3, the result.
- R5: If POLL_MAX status reads all return bit 0 clear, the result at address 3 is read anyway and the sequence continues unchanged.
- R6: After the result read, address 0 is written with bit 28 clear, then address 1 is written with 0. The code is updated only after that, and osc_en_o falls after the code update. Every bus transaction happens while osc_en_o is 1.
- R7: For a nonzero result r, code_o becomes round-half-up of q/1000, where q = floor(745472 / r).
- R8: A zero result gives code_o = 4.
- R9: A rounded value above 7 gives code_o = 7. For example, r = 99 gives 7.
- R10: done_o is high for exactly one cycle per run: the cycle right after osc_en_o falls.
- R11: A start_i pulse while a run is in progress is ignored. It does not change the channel, add transactions, or cause a second done pulse.
- R12: code_o keeps its value from the end of one run through the whole of the next run until that run's code-update step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| port_idx_i | input | CHAN_W | Port index, used as the meter channel |
| done_o | output | 1 | One-cycle completion pulse |
| osc_en_o | output | 1 | Ring-oscillator enable |
| code_o | output | CODE_W | Slew-rate code to the transmitter |
| reg_req_o | output | 1 | Bus request, held until acknowledged |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 2 | Meter register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_ack_i | input | 1 | Bus acknowledge, completes the transaction |
| reg_rdata_i | input | DATA_W | Read data, valid with reg_ack_i |

## Verification
The hardest situation to reach is the poll timeout. From the ports it looks like a normal run with a few extra reads, so the bench's meter model is told to withhold the valid bit for more reads than the budget allows. The bench then checks that the result is still read and used. The rounding edges (q = 500 against 499, a rounded 7 against a clamped 8) also need exact count values, and the table vectors choose those counts. A second start, injected while the sequencer is polling, covers the ignored-request case.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OSC_ON,
      ST_SETTLE,
      ST_FRK_ON,
      ST_CFG,
      ST_ARM,
      ST_POLL_RD,
      ST_POLL_WAIT,
      ST_RES_RD,
      ST_DISARM,
      ST_FRK_OFF,
      ST_DIV_GO,
      ST_DIV,
      ST_WR_CODE,
      ST_OSC_OFF,
      ST_DONE
   } seq_state_t;

   localparam logic [1:0] ADR_CFG  = 2'd0;
   localparam logic [1:0] ADR_FRK  = 2'd1;
   localparam logic [1:0] ADR_STAT = 2'd2;
   localparam logic [1:0] ADR_RES  = 2'd3;

   localparam int CFG_CNT_W  = 24;
   localparam int CFG_CH_LSB = 24;
   localparam int CFG_EN_BIT = 28;

endpackage

// File: rtl/srcal_tmr.sv
module srcal_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] val_i,
   output logic         exp_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (ld_i)            cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
   end

   assign exp_o = (cnt_q == '0);

   // R4: the wait counter counts down one per cycle until it is reloaded
   a_r4_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NUM_W-1:0] quot_o
);

   localparam int CNT_W = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("srcal_div: NUM_W must be at least 2");
   end

   logic [NUM_W-1:0] acc_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             fits;
   logic [DEN_W-1:0] rem_nxt;

   always_comb begin
      shifted = {rem_q, acc_q[NUM_W-1]};
      fits    = (shifted >= {1'b0, den_q});
      diff    = shifted - {1'b0, den_q};
      rem_nxt = fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !busy_q) begin
            acc_q  <= num_i;
            rem_q  <= '0;
            den_q  <= den_i;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            acc_q <= {acc_q[NUM_W-2:0], fits};
            rem_q <= rem_nxt;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign quot_o = acc_q;

   // R7: a launch always starts a busy period, and completion is a single pulse
   a_r7_div_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && !busy_q) |=> busy_o);
   a_r7_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_div_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: rtl/srcal_round.sv
module srcal_round #(
   parameter int Q_W    = 20,
   parameter int CODE_W = 3,
   parameter int SR_DIV = 1000
) (
   input  logic [Q_W-1:0]    quot_i,
   output logic [CODE_W-1:0] code_o
);

   localparam int NSTEP = (1 << CODE_W) - 1;

   if (Q_W > 32) begin : g_bad_q
      $error("srcal_round: Q_W must not exceed 32");
   end
   if (SR_DIV < 2) begin : g_bad_div
      $error("srcal_round: SR_DIV must be at least 2");
   end

   logic [NSTEP-1:0] hit;

   for (genvar k = 1; k <= NSTEP; k++) begin : g_thr
      localparam int unsigned THR = k * SR_DIV - SR_DIV / 2;
      assign hit[k-1] = (32'(quot_i) >= THR);
   end

   // thresholds rise with k, so the hits form a thermometer; its population is the
   // rounded quotient, saturating at NSTEP
   always_comb begin
      code_o = '0;
      for (int i = 0; i < NSTEP; i++) code_o = code_o + CODE_W'(hit[i]);
   end

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
   import srcal_pkg::*;
#(
   parameter int CHAN_W     = 2,
   parameter int DATA_W     = 32,
   parameter int CODE_W     = 3,
   parameter int DEF_CODE   = 4,
   parameter int FM_CYCLES  = 1024,
   parameter int REF_MHZ    = 26,
   parameter int SR_COEF    = 28,
   parameter int SR_DIV     = 1000,
   parameter int SETTLE_CYC = 100,
   parameter int POLL_CYC   = 1000,
   parameter int POLL_MAX   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CHAN_W-1:0] port_idx_i,
   output logic              done_o,
   output logic              osc_en_o,
   output logic [CODE_W-1:0] code_o,
   output logic              reg_req_o,
   output logic              reg_we_o,
   output logic [1:0]        reg_addr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic              reg_ack_i,
   input  logic [DATA_W-1:0] reg_rdata_i
);

   localparam int NUMER   = FM_CYCLES * REF_MHZ * SR_COEF;
   localparam int NUM_W   = $clog2(NUMER + 1);
   localparam int WAITMAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
   localparam int TMR_W   = $clog2(WAITMAX + 1);
   localparam int PC_W    = $clog2(POLL_MAX + 1);
   localparam int CLAMP_Q = (1 << CODE_W) * SR_DIV - SR_DIV / 2;

   if (DATA_W < 32) begin : g_bad_data
      $error("srcal_seq: DATA_W must be at least 32");
   end
   if (CHAN_W < 1 || CHAN_W > CFG_EN_BIT - CFG_CH_LSB) begin : g_bad_chan
      $error("srcal_seq: CHAN_W out of range");
   end
   if (FM_CYCLES < 1 || FM_CYCLES >= (1 << CFG_CNT_W)) begin : g_bad_cnt
      $error("srcal_seq: FM_CYCLES does not fit the count field");
   end
   if (DEF_CODE >= (1 << CODE_W)) begin : g_bad_def
      $error("srcal_seq: DEF_CODE does not fit CODE_W");
   end
   if (POLL_MAX < 1 || SETTLE_CYC < 1 || POLL_CYC < 1) begin : g_bad_wait
      $error("srcal_seq: wait parameters must be positive");
   end

   seq_state_t        st_q, st_d;
   logic [CHAN_W-1:0] chan_q;
   logic              osc_q;
   logic [CODE_W-1:0] code_q;
   logic [PC_W-1:0]   poll_q;
   logic [DATA_W-1:0] res_q;

   logic              res_zero;
   logic              last_poll;
   logic              stat_valid;
   logic              tmr_ld;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_exp;
   logic              div_go;
   logic              div_busy;
   logic              div_done;
   logic [NUM_W-1:0]  div_quot;
   logic [CODE_W-1:0] rnd_code;
   logic [DATA_W-1:0] cfg_word;

   assign res_zero   = (res_q == '0);
   assign last_poll  = (poll_q == PC_W'(POLL_MAX - 1));
   assign stat_valid = reg_rdata_i[0];

   always_comb begin
      cfg_word = '0;
      cfg_word[CFG_CNT_W-1:0]           = CFG_CNT_W'(FM_CYCLES);
      cfg_word[CFG_CH_LSB +: CHAN_W]    = chan_q;
   end

   // ---- bus request decode -------------------------------------------------
   always_comb begin
      reg_req_o   = 1'b0;
      reg_we_o    = 1'b0;
      reg_addr_o  = ADR_CFG;
      reg_wdata_o = '0;
      unique case (st_q)
         ST_FRK_ON:  begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = ADR_FRK;
                           reg_wdata_o = DATA_W'(1); end
         ST_CFG:     begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = ADR_CFG;
                           reg_wdata_o = cfg_word; end
         ST_ARM:     begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = ADR_CFG;
                           reg_wdata_o = cfg_word | (DATA_W'(1) << CFG_EN_BIT); end
         ST_POLL_RD: begin reg_req_o = 1'b1; reg_addr_o = ADR_STAT; end
         ST_RES_RD:  begin reg_req_o = 1'b1; reg_addr_o = ADR_RES; end
         ST_DISARM:  begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = ADR_CFG;
                           reg_wdata_o = cfg_word; end
         ST_FRK_OFF: begin reg_req_o = 1'b1; reg_we_o = 1'b1; reg_addr_o = ADR_FRK; end
         default: ;
      endcase
   end

   // ---- wait timer control -------------------------------------------------
   always_comb begin
      tmr_ld  = 1'b0;
      tmr_val = TMR_W'(SETTLE_CYC);
      if (st_q == ST_OSC_ON) begin
         tmr_ld = 1'b1;
      end else if (st_q == ST_POLL_RD && reg_ack_i && !stat_valid && !last_poll) begin
         tmr_ld  = 1'b1;
         tmr_val = TMR_W'(POLL_CYC);
      end
   end

   assign div_go = (st_q == ST_DIV_GO) && !res_zero;

   // ---- next state ---------------------------------------------------------
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:      if (start_i) st_d = ST_OSC_ON;
         ST_OSC_ON:    st_d = ST_SETTLE;
         ST_SETTLE:    if (tmr_exp) st_d = ST_FRK_ON;
         ST_FRK_ON:    if (reg_ack_i) st_d = ST_CFG;
         ST_CFG:       if (reg_ack_i) st_d = ST_ARM;
         ST_ARM:       if (reg_ack_i) st_d = ST_POLL_RD;
         ST_POLL_RD:   if (reg_ack_i) st_d = (stat_valid || last_poll) ? ST_RES_RD : ST_POLL_WAIT;
         ST_POLL_WAIT: if (tmr_exp) st_d = ST_POLL_RD;
         ST_RES_RD:    if (reg_ack_i) st_d = ST_DISARM;
         ST_DISARM:    if (reg_ack_i) st_d = ST_FRK_OFF;
         ST_FRK_OFF:   if (reg_ack_i) st_d = ST_DIV_GO;
         ST_DIV_GO:    st_d = res_zero ? ST_WR_CODE : ST_DIV;
         ST_DIV:       if (div_done) st_d = ST_WR_CODE;
         ST_WR_CODE:   st_d = ST_OSC_OFF;
         ST_OSC_OFF:   st_d = ST_DONE;
         ST_DONE:      st_d = ST_IDLE;
         default:      st_d = ST_IDLE;
      endcase
   end

   // ---- state and data registers -------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         chan_q <= '0;
         osc_q  <= 1'b0;
         code_q <= CODE_W'(DEF_CODE);
         poll_q <= '0;
         res_q  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start_i) chan_q <= port_idx_i;
         if (st_q == ST_OSC_ON)  osc_q <= 1'b1;
         if (st_q == ST_OSC_OFF) osc_q <= 1'b0;
         if (st_q == ST_ARM) poll_q <= '0;
         else if (st_q == ST_POLL_RD && reg_ack_i) poll_q <= poll_q + PC_W'(1);
         if (st_q == ST_RES_RD && reg_ack_i) res_q <= reg_rdata_i;
         if (st_q == ST_WR_CODE) code_q <= res_zero ? CODE_W'(DEF_CODE) : rnd_code;
      end
   end

   assign osc_en_o = osc_q;
   assign code_o   = code_q;
   assign done_o   = (st_q == ST_DONE);

   srcal_tmr #(.W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_i  (tmr_ld),
      .val_i (tmr_val),
      .exp_o (tmr_exp)
   );

   srcal_div #(.NUM_W(NUM_W), .DEN_W(DATA_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (NUM_W'(NUMER)),
      .den_i  (res_q),
      .busy_o (div_busy),
      .done_o (div_done),
      .quot_o (div_quot)
   );

   srcal_round #(.Q_W(NUM_W), .CODE_W(CODE_W), .SR_DIV(SR_DIV)) u_round (
      .quot_i (div_quot),
      .code_o (rnd_code)
   );

   // ---- assertions ---------------------------------------------------------
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
                                     && $stable(reg_we_o) && $stable(reg_wdata_o)));
   a_r6_bus_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_o |-> osc_en_o);
   a_r7_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !reg_req_o);
   a_r8_zero_default: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WR_CODE && res_zero) |=> (code_o == CODE_W'(DEF_CODE)));
   a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WR_CODE && !res_zero && 32'(div_quot) >= CLAMP_Q) |=> (code_o == '1));
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r10_osc_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!osc_en_o && $past(osc_en_o)));
   a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(chan_q));
   a_r12_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_WR_CODE) |=> $stable(code_o));

endmodule

// File: tb/srcal_seq_tb.sv
module srcal_seq_tb;

   localparam int SETTLE = 5;
   localparam int POLLC  = 12;
   localparam int PMAX   = 4;
   localparam int NV     = 14;
   localparam int LOGN   = 512;

   // result, status reads returned invalid before valid, channel, expected code
   localparam int V_RES [NV] = '{1000, 100, 120, 150, 200, 250, 300, 745472,
                                 1490, 1491, 114, 115, 99, 0};
   localparam int V_VA  [NV] = '{0, 1, 2, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0};
   localparam int V_CH  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3, 0, 1};
   localparam int V_EXP [NV] = '{1, 7, 6, 5, 4, 3, 2, 0, 1, 0, 7, 6, 7, 4};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  port_idx = '0;
   logic        done, osc_en, req, we, ack;
   logic [2:0]  code;
   logic [1:0]  addr;
   logic [31:0] wdata, rdata;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   int          res_val = 0, valid_after = 0, stat_base = 0;
   int          cyc = 0, n_tx = 0, stat_reads = 0, done_cnt = 0, osc_rise = 0;
   bit          osc_prev = 1'b0, done_prev = 1'b0, dbl_done = 1'b0, osc_at_done = 1'b0;
   logic [1:0]  l_addr [LOGN];
   logic        l_we   [LOGN];
   logic [31:0] l_data [LOGN];
   logic        l_osc  [LOGN];
   logic [2:0]  l_code [LOGN];
   int          l_cyc  [LOGN];

   always #5 clk = ~clk;

   srcal_seq #(.SETTLE_CYC(SETTLE), .POLL_CYC(POLLC), .POLL_MAX(PMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .port_idx_i(port_idx),
      .done_o(done), .osc_en_o(osc_en), .code_o(code),
      .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
      .reg_ack_i(ack), .reg_rdata_i(rdata));

   // meter model and transaction log
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
         rdata <= '0;
      end else begin
         cyc <= cyc + 1;
         osc_prev <= osc_en;
         if (osc_en && !osc_prev) osc_rise <= cyc;
         done_prev <= done;
         if (done) begin
            done_cnt <= done_cnt + 1;
            if (osc_en) osc_at_done <= 1'b1;
            if (done_prev) dbl_done <= 1'b1;
         end
         if (req && ack && n_tx < LOGN) begin
            l_addr[n_tx] <= addr;
            l_we[n_tx]   <= we;
            l_data[n_tx] <= we ? wdata : rdata;
            l_osc[n_tx]  <= osc_en;
            l_code[n_tx] <= code;
            l_cyc[n_tx]  <= cyc;
            n_tx <= n_tx + 1;
         end
         if (req && !ack) begin
            ack <= 1'b1;
            if (!we && addr == 2'd2) begin
               rdata <= (stat_reads - stat_base >= valid_after) ? 32'd1 : 32'd0;
               stat_reads <= stat_reads + 1;
            end else if (!we && addr == 2'd3) rdata <= 32'(res_val);
            else rdata <= '0;
         end else ack <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic run_one(input int res, input int va, input int ch, input int exp_code,
                          input bit poke);
      int base, d0, prev, nst, n, p;
      logic [31:0] cfg;
      res_val = res;
      valid_after = va;
      stat_base = stat_reads;
      base = n_tx;
      d0 = done_cnt;
      prev = int'(code);
      @(negedge clk); start = 1'b1; port_idx = 2'(ch);
      @(negedge clk); start = 1'b0;
      if (poke) begin
         repeat (SETTLE + 8) @(negedge clk);
         start = 1'b1; port_idx = 2'(ch ^ 1);
         @(negedge clk); start = 1'b0;
      end
      while (done_cnt == d0) @(negedge clk);
      repeat (3) @(negedge clk);
      nst = (va + 1 < PMAX) ? va + 1 : PMAX;
      n = n_tx - base;
      cfg = 32'd1024 | (32'(ch) << 24);
      chk(n == nst + 6, "R2 transaction count", n, nst + 6);
      if (n == nst + 6) begin
         chk(l_we[base] && l_addr[base] == 2'd1 && l_data[base] == 32'd1,
             "R2 first write free-run on", longint'(l_data[base]), 1);
         chk(l_cyc[base] - osc_rise >= SETTLE, "R2 settle before first write",
             l_cyc[base] - osc_rise, SETTLE);
         chk(l_we[base+1] && l_addr[base+1] == 2'd0 && l_data[base+1] == cfg,
             "R3 config word", longint'(l_data[base+1]), longint'(cfg));
         chk(l_we[base+2] && l_addr[base+2] == 2'd0 && l_data[base+2] == (cfg | (32'd1 << 28)),
             "R3 arm word", longint'(l_data[base+2]), longint'(cfg | (32'd1 << 28)));
         for (int k = 0; k < nst; k++) begin
            chk(!l_we[base+3+k] && l_addr[base+3+k] == 2'd2, "R4 status read",
                longint'(l_addr[base+3+k]), 2);
            if (k > 0) begin
               p = l_cyc[base+3+k] - l_cyc[base+2+k];
               chk(p >= POLLC, "R4 poll spacing", p, POLLC);
            end
         end
         chk(!l_we[base+3+nst] && l_addr[base+3+nst] == 2'd3, "R5 result read",
             longint'(l_addr[base+3+nst]), 3);
         chk(l_we[base+4+nst] && l_addr[base+4+nst] == 2'd0 && l_data[base+4+nst] == cfg,
             "R6 disarm write", longint'(l_data[base+4+nst]), longint'(cfg));
         chk(l_we[base+5+nst] && l_addr[base+5+nst] == 2'd1 && l_data[base+5+nst] == 32'd0,
             "R6 free-run off write", longint'(l_addr[base+5+nst]), 1);
         for (int k = 0; k < n; k++) begin
            chk(l_osc[base+k] == 1'b1, "R6 bus access with oscillator on", l_osc[base+k], 1);
            chk(int'(l_code[base+k]) == prev, "R12 code held during run",
                l_code[base+k], prev);
         end
      end
      chk(int'(code) == exp_code, (res == 0) ? "R8 zero default" :
          (exp_code == 7) ? "R9 clamp or R7 code" : "R7 code", code, exp_code);
      chk(osc_en == 1'b0, "R10 oscillator off after done", osc_en, 0);
      chk(done_cnt == d0 + 1, poke ? "R11 single done" : "R10 one done per run",
          done_cnt, d0 + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      int before_tx, before_done, held;
      repeat (3) @(negedge clk);
      chk(osc_en == 1'b0 && done == 1'b0 && req == 1'b0, "R1 outputs in reset",
          {osc_en, done, req}, 0);
      chk(code == 3'd4, "R1 code in reset", code, 4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(code == 3'd4 && osc_en == 1'b0 && req == 1'b0, "R1 after reset release", code, 4);

      for (int i = 0; i < NV; i++) run_one(V_RES[i], V_VA[i], V_CH[i], V_EXP[i], 1'b0);

      // R5: meter never reports valid; result still read and used
      run_one(300, 99, 1, 2, 1'b0);
      // R11: second start during polling is ignored
      run_one(200, 3, 2, 4, 1'b1);
      before_tx = n_tx;
      before_done = done_cnt;
      repeat (60) @(negedge clk);
      chk(n_tx == before_tx, "R11 no extra transactions", n_tx, before_tx);
      chk(done_cnt == before_done, "R11 no extra done", done_cnt, before_done);
      // R12: code held while idle
      held = int'(code);
      chk(held == 4, "R12 code held after run", held, 4);
      chk(dbl_done == 1'b0, "R10 done lasts one cycle", dbl_done, 0);
      chk(osc_at_done == 1'b0, "R10 oscillator low while done", osc_at_done, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule